// File: doc/BRIEF.md
# Dual-Bank Frame Settings Register File

This block keeps two complete copies, bank A and bank B, of the settings that frame timing logic needs for each frame. The settings are integration time, line length, frame length, window start and end coordinates, skip increments, binning modes, per-color and global gains, and a mode word. Software loads either bank over a simple synchronous register bus and can read any stored word back. A single select bit, held in a control register on the same bus, names the bank that should drive the sensor.

The select bit does not take effect at once. It is acted on only at frame-start pulses, and it is applied in two stages. The integration-time word follows the new bank from the next frame. Every other setting follows one frame later. Exposure for a frame is set up during the frame before it is read out, so this ordering keeps each output frame uniformly exposed. The effective settings are presented as one flat registered vector, one DATA_W-wide slice per field.

Top module: `ctx_bank_regfile`

## Requirements
- R1: After synchronous reset, bank A feeds every field, all stored words and the select bit are zero, and every slice of `eff_cfg` and `rd_data` is zero.
- R2: Bus address decode: if `wr_addr`/`rd_addr` bit ADDR_W-1 is 1, the address is the control register, and data bit 0 is the select (0 = bank A, 1 = bank B). Otherwise bit FIELD_W picks the bank (0 = A, 1 = B) and bits FIELD_W-1:0 give the field index. `rd_data` returns the addressed stored word at the rising edge after `rd_addr` is presented, whichever bank is active. A control read returns the select in bit 0 and zeros above it.
- R3: Field 0 is the integration time. Field f appears on `eff_cfg[f*DATA_W +: DATA_W]`.
- R4: After the select is changed, the integration-time slice switches to the new bank's word one clock after the next `frame_start` pulse, and not before.
- R5: The slices of fields 1 to NUM_FIELDS-1 switch to the bank that the integration time used during the previous frame. A select change therefore reaches them one clock after the second `frame_start` pulse.
- R6: Switching from B to A follows the same two-stage timing as switching from A to B.
- R7: Only the select value present at a `frame_start` pulse is acted on. Changing the select and changing it back within one frame has no effect on any slice.
- R8: A write to a bank that currently feeds no field leaves every slice of `eff_cfg` unchanged.
- R9: A write sampled at rising edge k to a field fed from that bank shows on `eff_cfg` from rising edge k+1.
- R10: Writes to a field index of NUM_FIELDS or above are ignored, and reads of such an index return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register bus |
| wr_addr | input | ADDR_W | Write address (control flag, bank bit, field index) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Registered read data, one cycle after `rd_addr` |
| frame_start | input | 1 | One-cycle pulse marking the start of a frame |
| eff_cfg | output | NUM_FIELDS*DATA_W | Registered effective settings, one slice per field |

## Verification
Every result has a fixed latency. Read data is due at the rising edge after the address is presented. A stored word reaches its output slice at the rising edge after the write edge. A bank change reaches its slices at the rising edge after the `frame_start` edge that applies it. The bench drives all inputs on falling edges and samples on falling edges. After each stimulus it waits exactly the number of edges stated above. For write timing it also samples one edge early, so a result that arrives too soon is caught as well as one that arrives too late. Select changes are checked against each field slice before the first pulse, between the two pulses and after the second.

// File: rtl/ctx_pkg.sv
package ctx_pkg;
  typedef enum logic {BANK_A = 1'b0, BANK_B = 1'b1} bank_e;
  // Field index whose bank follows the select one frame ahead of the rest
  localparam int INT_TIME_FIELD = 0;
endpackage

// File: rtl/ctx_bank_store.sv
module ctx_bank_store
  import ctx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_FIELDS = 20,
  parameter int FIELD_W    = 5,
  localparam int ADDR_W    = FIELD_W + 2,
  localparam int FLAT_W    = NUM_FIELDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output bank_e             sel_q,
  output logic [FLAT_W-1:0] bank_a_flat,
  output logic [FLAT_W-1:0] bank_b_flat
);
  logic [DATA_W-1:0] mem [2][NUM_FIELDS];

  logic               wr_ctrl, wr_hit, wr_bank;
  logic [FIELD_W-1:0] wr_field;
  logic               rd_ctrl, rd_in_range, rd_bank;
  logic [FIELD_W-1:0] rd_field;
  logic [DATA_W-1:0]  rd_next;

  assign wr_ctrl  = wr_addr[ADDR_W-1];
  assign wr_bank  = wr_addr[FIELD_W];
  assign wr_field = wr_addr[FIELD_W-1:0];
  assign wr_hit   = wr_en && !wr_ctrl &&
                    ({1'b0, wr_field} < (FIELD_W+1)'(NUM_FIELDS));

  assign rd_ctrl     = rd_addr[ADDR_W-1];
  assign rd_bank     = rd_addr[FIELD_W];
  assign rd_field    = rd_addr[FIELD_W-1:0];
  assign rd_in_range = ({1'b0, rd_field} < (FIELD_W+1)'(NUM_FIELDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < 2; b++)
        for (int f = 0; f < NUM_FIELDS; f++)
          mem[b][f] <= '0;
    end else if (wr_hit) begin
      mem[wr_bank][wr_field] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                    sel_q <= BANK_A;
    else if (wr_en && wr_ctrl)  sel_q <= bank_e'(wr_data[0]);
  end

  always_comb begin
    rd_next = '0;
    if (rd_ctrl)          rd_next[0] = sel_q;
    else if (rd_in_range) rd_next    = mem[rd_bank][rd_field];
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_next;
  end

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_flat
    assign bank_a_flat[f*DATA_W +: DATA_W] = mem[0][f];
    assign bank_b_flat[f*DATA_W +: DATA_W] = mem[1][f];
  end
endmodule

// File: rtl/ctx_switch_sched.sv
module ctx_switch_sched
  import ctx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  bank_e sel_q,
  input  logic  frame_start,
  output bank_e int_bank_q,
  output bank_e cfg_bank_q
);
  // Integration time takes the select at a frame start; the other
  // settings take what the integration time used during the frame before.
  always_ff @(posedge clk) begin
    if (rst) begin
      int_bank_q <= BANK_A;
      cfg_bank_q <= BANK_A;
    end else if (frame_start) begin
      int_bank_q <= sel_q;
      cfg_bank_q <= int_bank_q;
    end
  end
endmodule

// File: rtl/ctx_eff_mux.sv
module ctx_eff_mux
  import ctx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_FIELDS = 20,
  localparam int FLAT_W    = NUM_FIELDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FLAT_W-1:0] bank_a_flat,
  input  logic [FLAT_W-1:0] bank_b_flat,
  input  bank_e             int_bank_q,
  input  bank_e             cfg_bank_q,
  output logic [FLAT_W-1:0] eff_cfg
);
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    bank_e src;
    if (f == INT_TIME_FIELD) begin : g_int
      assign src = int_bank_q;
    end else begin : g_cfg
      assign src = cfg_bank_q;
    end

    always_ff @(posedge clk) begin
      if (rst)
        eff_cfg[f*DATA_W +: DATA_W] <= '0;
      else if (src == BANK_B)
        eff_cfg[f*DATA_W +: DATA_W] <= bank_b_flat[f*DATA_W +: DATA_W];
      else
        eff_cfg[f*DATA_W +: DATA_W] <= bank_a_flat[f*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/ctx_bank_regfile.sv
module ctx_bank_regfile
  import ctx_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int NUM_FIELDS = 20,
  localparam int FIELD_W   = $clog2(NUM_FIELDS),
  localparam int ADDR_W    = FIELD_W + 2,
  localparam int FLAT_W    = NUM_FIELDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              frame_start,
  output logic [FLAT_W-1:0] eff_cfg
);
  bank_e             sel_q, int_bank_q, cfg_bank_q;
  logic [FLAT_W-1:0] bank_a_flat, bank_b_flat;

  ctx_bank_store #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_q(sel_q),
    .bank_a_flat(bank_a_flat), .bank_b_flat(bank_b_flat)
  );

  ctx_switch_sched u_sched (
    .clk(clk), .rst(rst), .sel_q(sel_q), .frame_start(frame_start),
    .int_bank_q(int_bank_q), .cfg_bank_q(cfg_bank_q)
  );

  ctx_eff_mux #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)) u_mux (
    .clk(clk), .rst(rst), .bank_a_flat(bank_a_flat), .bank_b_flat(bank_b_flat),
    .int_bank_q(int_bank_q), .cfg_bank_q(cfg_bank_q), .eff_cfg(eff_cfg)
  );
endmodule

// File: rtl/ctx_bank_regfile_chk.sv
module ctx_bank_regfile_chk #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              frame_start,
  input logic              sel_q,
  input logic              int_bank_q,
  input logic              cfg_bank_q
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: a reset cycle leaves bank A feeding every field and select at A
  always @(posedge clk)
    if (rst_d === 1'b1)
      a_r1_reset_bank_a: assert (int_bank_q == 1'b0 && cfg_bank_q == 1'b0 && sel_q == 1'b0);

  // R2: a control write loads the select from data bit 0
  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr[ADDR_W-1]) |=> (sel_q == $past(wr_data[0])));

  // R4: integration-time bank takes the select present at frame start
  a_r4_int_takes_sel: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (int_bank_q == $past(sel_q)));

  // R5: other settings take the previous integration-time bank
  a_r5_cfg_lags_int: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (cfg_bank_q == $past(int_bank_q)));

  // R7: no bank moves between frame starts
  a_r7_hold_in_frame: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(int_bank_q) && $stable(cfg_bank_q)));
endmodule

bind ctx_bank_regfile ctx_bank_regfile_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .frame_start(frame_start), .sel_q(sel_q), .int_bank_q(int_bank_q),
  .cfg_bank_q(cfg_bank_q)
);

// File: tb/sim_ctx_bank_regfile.sv
module sim_ctx_bank_regfile;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 16;
  localparam int NUM_FIELDS = 20;
  localparam int ADDR_W     = 7;
  localparam logic [ADDR_W-1:0] CTRL = 7'h40;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0, frame_start = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [NUM_FIELDS*DATA_W-1:0] eff_cfg;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  ctx_bank_regfile #(.DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .frame_start(frame_start), .eff_cfg(eff_cfg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [ADDR_W-1:0] a_adr(int f); return ADDR_W'(f); endfunction
  function automatic logic [ADDR_W-1:0] b_adr(int f); return ADDR_W'(32 + f); endfunction

  task automatic chk(string req, logic [DATA_W-1:0] got, logic [DATA_W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_eff(string req, int f, logic [DATA_W-1:0] exp);
    chk($sformatf("%s field %0d", req, f), eff_cfg[f*DATA_W +: DATA_W], exp);
  endtask

  // write sampled at the next rising edge; returns at the falling edge after it
  task automatic wr(logic [ADDR_W-1:0] a, logic [DATA_W-1:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  // pulse frame start, then wait for the output register edge
  task automatic frame();
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] d;
    for (int f = 0; f < NUM_FIELDS; f++) chk_eff("R1 reset eff", f, 16'h0000);
    rd(b_adr(3), d); chk("R1 reset B3 read", d, 16'h0000);
    rd(CTRL, d);     chk("R1 reset select", d, 16'h0000);
  endtask

  task automatic t_fill();
    logic [DATA_W-1:0] d;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      wr(a_adr(f), DATA_W'(16'h1000 + f));
      wr(b_adr(f), DATA_W'(16'h2000 + f));
    end
    @(negedge clk);
    rd(a_adr(7), d);  chk("R2 read A7", d, 16'h1007);
    rd(b_adr(19), d); chk("R2 read B19", d, 16'h2013);
    chk_eff("R3 int field A", 0, 16'h1000);
    chk_eff("R3 last field A", 19, 16'h1013);
    // R9: write edge k -> output at edge k+1
    wr(a_adr(5), 16'h5555);
    chk_eff("R9 not before k+1", 5, 16'h1005);
    @(negedge clk);
    chk_eff("R9 at k+1", 5, 16'h5555);
    wr(a_adr(5), 16'h1005);
    @(negedge clk);
  endtask

  task automatic t_a_to_b();
    wr(CTRL, 16'h0001);
    @(negedge clk);
    chk_eff("R4 no early switch", 0, 16'h1000);
    frame();
    chk_eff("R4 int from B after 1st frame", 0, 16'h2000);
    chk_eff("R5 cfg still A after 1st frame", 1, 16'h1001);
    frame();
    chk_eff("R5 cfg B after 2nd frame", 1, 16'h2001);
    chk_eff("R5 cfg B after 2nd frame", 19, 16'h2013);
  endtask

  task automatic t_inactive_write();
    logic [DATA_W-1:0] d;
    wr(a_adr(0), 16'hBEEF);
    wr(a_adr(7), 16'hCAFE);
    repeat (2) @(negedge clk);
    chk_eff("R8 inactive int", 0, 16'h2000);
    chk_eff("R8 inactive cfg", 7, 16'h2007);
    rd(a_adr(0), d); chk("R2 read inactive A0", d, 16'hBEEF);
    wr(a_adr(0), 16'h1000);
    wr(a_adr(7), 16'h1007);
  endtask

  task automatic t_b_to_a();
    wr(CTRL, 16'h0000);
    frame();
    chk_eff("R6 int A after 1st frame", 0, 16'h1000);
    chk_eff("R6 cfg B after 1st frame", 2, 16'h2002);
    frame();
    chk_eff("R6 cfg A after 2nd frame", 2, 16'h1002);
  endtask

  task automatic t_toggle();
    logic [DATA_W-1:0] d;
    wr(CTRL, 16'h0001);
    wr(CTRL, 16'h0000);
    rd(CTRL, d); chk("R2 ctrl read", d, 16'h0000);
    frame();
    chk_eff("R7 toggle int", 0, 16'h1000);
    frame();
    chk_eff("R7 toggle cfg", 3, 16'h1003);
    // change, apply once, change back before the second pulse
    wr(CTRL, 16'h0001);
    frame();
    chk_eff("R4 int B", 0, 16'h2000);
    chk_eff("R5 cfg A", 3, 16'h1003);
    wr(CTRL, 16'h0000);
    frame();
    chk_eff("R4 int back to A", 0, 16'h1000);
    chk_eff("R5 cfg takes B one frame late", 3, 16'h2003);
    frame();
    chk_eff("R5 cfg back to A", 3, 16'h1003);
  endtask

  task automatic t_out_of_range();
    logic [DATA_W-1:0] d;
    wr(a_adr(25), 16'hFFFF);
    wr(b_adr(31), 16'hFFFF);
    wr(CTRL, 16'hFFFE);
    rd(a_adr(25), d); chk("R10 read A25", d, 16'h0000);
    rd(b_adr(31), d); chk("R10 read B31", d, 16'h0000);
    rd(CTRL, d);      chk("R2 ctrl upper bits", d, 16'h0000);
    for (int f = 0; f < NUM_FIELDS; f++) chk_eff("R10 eff intact", f, DATA_W'(16'h1000 + f));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    t_reset();
    t_fill();
    t_a_to_b();
    t_inactive_write();
    t_b_to_a();
    t_toggle();
    t_out_of_range();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule